// File: doc/BRIEF.md
# Partial-Reconfiguration Isolation Controller

This block separates a reprogrammable logic region from the surrounding static logic while new configuration is loaded into that region. Software reaches it through four 32-bit registers on a plain word-addressed read/write bus. It asks for the region to be frozen, waits for a completion bit, may then hold the region in reset, and at the end asks for it to be released. The controller drives two outputs to the region: an isolation (freeze) level and an active-high reset. Any request made in the wrong order, or with several request bits set at once, is refused and recorded in a sticky error register.

The sequencing is a four-state machine:

- **ST_RUN** is the unfrozen state and the state after reset.
- **ST_DRAIN** asserts freeze and waits for the region to drain.
- **ST_HELD** is the frozen state, where a reset request is allowed.
- **ST_SETTLE** releases reset and keeps freeze raised for a settle time.

The transitions are:

- **GO_FREEZE**: ST_RUN to ST_DRAIN, on an accepted freeze request.
- **DRAINED**: ST_DRAIN to ST_HELD, when the drain count expires or the quiet input is high.
- **GO_THAW**: ST_HELD to ST_SETTLE, on an accepted unfreeze request.
- **SETTLED**: ST_SETTLE to ST_RUN, when the settle count expires.

Word address map:

| Word address | Register | Access |
|---|---|---|
| 0 | status | read |
| 1 | control | read/write |
| 2 | error | read, write 1 to clear |
| 3 | revision | read |

Top module: `pr_isolation_ctrl`

## Requirements
- R1: After reset, status reads 2 (bit 1 set, bit 0 clear), control and error read 0, and region_freeze and region_reset are low.
- R2: Word address 3 always reads the constant REG_REVISION (default 2), and writes to it change nothing.
- R3: An accepted freeze request (control written with exactly 1 in ST_RUN) raises region_freeze on the clock edge that takes the write. Status stays 2 for DRAIN_CYCLES-1 further edges and reads 1 after DRAIN_CYCLES edges.
- R4: While in ST_DRAIN, region_quiet high on a clock edge ends the drain on that edge, so status reads 1 one edge after the freeze write.
- R5: Exactly one of status bits 0 and 1 is set at all times. Bit 1 is held through ST_DRAIN and bit 0 is held through ST_SETTLE.
- R6: region_reset is high exactly while control bit 1 is set and the controller is in ST_HELD. A reset request (value 2) written in ST_HELD is accepted.
- R7: An accepted unfreeze request (value 4 in ST_HELD) drops region_reset on the write edge. region_freeze stays high for SETTLE_CYCLES-1 further edges, and then freeze falls and status reads 2 after SETTLE_CYCLES edges.
- R8: A freeze request outside ST_RUN sets error bit 0, and the state and status are unchanged.
- R9: A reset request outside ST_HELD sets error bit 1, and control keeps its previous value.
- R10: An unfreeze request outside ST_HELD sets error bit 2, and the state is unchanged.
- R11: A control write with more than one of bits 2:0 set, or with any of bits 31:3 set, sets error bit 0 and is otherwise ignored.
- R12: Error bits stay set until a write to address 2 with data bit 0 set clears them all. A write there with data bit 0 clear has no effect.
- R13: Writing 0 to control is accepted in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| region_quiet | input | 1 | Region reports it has drained |
| region_freeze | output | 1 | Isolation level to the region |
| region_reset | output | 1 | Active-high reset to the region |

## Verification
The hardest case to reach from the ports is the reset request accepted only in ST_HELD, together with its removal by the unfreeze write. The stimulus drives the full freeze drain with region_quiet held low, waits on exact cycle counts, and only then issues the reset request. It then issues the unfreeze, so the same-edge fall of region_reset and the settle count can both be observed. Illegal requests are issued both in ST_RUN and in ST_HELD, and the error register, control and status are read back after each one.

// File: rtl/pr_iso_pkg.sv
package pr_iso_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_HELD   = 2'd2,
        ST_SETTLE = 2'd3
    } iso_state_t;

    localparam logic [1:0] A_STATUS = 2'd0;
    localparam logic [1:0] A_CTRL   = 2'd1;
    localparam logic [1:0] A_ERR    = 2'd2;
    localparam logic [1:0] A_REV    = 2'd3;

    localparam logic [2:0] REQ_FREEZE = 3'b001;
    localparam logic [2:0] REQ_RESET  = 3'b010;
    localparam logic [2:0] REQ_THAW   = 3'b100;
endpackage

// File: rtl/pr_iso_timer.sv
module pr_iso_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] terminal,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == terminal);
endmodule

// File: rtl/pr_iso_fsm.sv
module pr_iso_fsm
    import pr_iso_pkg::*;
#(
    parameter int DRAIN_CYCLES  = 16,
    parameter int SETTLE_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_freeze,
    input  logic       start_thaw,
    input  logic       region_quiet,
    output iso_state_t state,
    output logic [1:0] status,
    output logic       freeze_o
);
    localparam int MAXC = (DRAIN_CYCLES > SETTLE_CYCLES) ? DRAIN_CYCLES : SETTLE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DRAIN_TC  = CW'(DRAIN_CYCLES - 1);
    localparam logic [CW-1:0] SETTLE_TC = CW'(SETTLE_CYCLES - 1);

    iso_state_t    nxt;
    logic          tmr_done;
    logic [CW-1:0] tmr_tc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // Transitions: GO_FREEZE, DRAINED, GO_THAW, SETTLED
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:    if (start_freeze)            nxt = ST_DRAIN;
            ST_DRAIN:  if (region_quiet || tmr_done) nxt = ST_HELD;
            ST_HELD:   if (start_thaw)              nxt = ST_SETTLE;
            ST_SETTLE: if (tmr_done)                nxt = ST_RUN;
            default:                                nxt = ST_RUN;
        endcase
    end

    assign tmr_tc = (state == ST_DRAIN) ? DRAIN_TC : SETTLE_TC;

    pr_iso_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (nxt != state),
        .terminal (tmr_tc),
        .expired  (tmr_done)
    );

    // Outputs
    always_comb begin
        status   = 2'b10;
        freeze_o = 1'b0;
        unique case (state)
            ST_RUN:    begin status = 2'b10; freeze_o = 1'b0; end
            ST_DRAIN:  begin status = 2'b10; freeze_o = 1'b1; end
            ST_HELD:   begin status = 2'b01; freeze_o = 1'b1; end
            ST_SETTLE: begin status = 2'b01; freeze_o = 1'b1; end
            default:   begin status = 2'b10; freeze_o = 1'b0; end
        endcase
    end

    // R5
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status) == 1);

    // R3
    done_after_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(freeze_o));

    // R7
    release_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(freeze_o) |-> status == 2'b10);
endmodule

// File: rtl/pr_iso_regs.sv
module pr_iso_regs
    import pr_iso_pkg::*;
#(
    parameter int DW           = 32,
    parameter int REG_REVISION = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  iso_state_t    state,
    input  logic [1:0]    status,
    output logic          start_freeze,
    output logic          start_thaw,
    output logic          region_reset
);
    logic [2:0] ctrl;
    logic [2:0] err;
    logic       wr_ctrl, wr_err, in_run, in_held;
    logic       multi, req_frz, req_rst, req_thw;
    logic       bad_frz, bad_rst, bad_thw, accept;

    assign in_run  = (state == ST_RUN);
    assign in_held = (state == ST_HELD);
    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
    assign wr_err  = bus_sel && bus_wr && (bus_addr == A_ERR);

    assign multi   = ($countones(bus_wdata[2:0]) > 1) || (|bus_wdata[DW-1:3]);
    assign req_frz = !multi && (bus_wdata[2:0] == REQ_FREEZE);
    assign req_rst = !multi && (bus_wdata[2:0] == REQ_RESET);
    assign req_thw = !multi && (bus_wdata[2:0] == REQ_THAW);

    assign bad_frz = wr_ctrl && (multi || (req_frz && !in_run));
    assign bad_rst = wr_ctrl && req_rst && !in_held;
    assign bad_thw = wr_ctrl && req_thw && !in_held;
    assign accept  = wr_ctrl && !bad_frz && !bad_rst && !bad_thw;

    assign start_freeze = wr_ctrl && req_frz && in_run;
    assign start_thaw   = wr_ctrl && req_thw && in_held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl <= '0;
        else if (accept) ctrl <= bus_wdata[2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    err <= '0;
        else if (wr_err && bus_wdata[0]) err <= '0;
        else                           err <= err | {bad_thw, bad_rst, bad_frz};
    end

    assign region_reset = ctrl[1] && in_held;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_STATUS: bus_rdata[1:0] = status;
            A_CTRL:   bus_rdata[2:0] = ctrl;
            A_ERR:    bus_rdata[2:0] = err;
            A_REV:    bus_rdata      = DW'(REG_REVISION);
            default:  bus_rdata      = '0;
        endcase
    end

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_err && bus_wdata[0]) |=> ((err & $past(err)) == $past(err)));

    // R9
    ctrl_hold_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !accept) |=> $stable(ctrl));
endmodule

// File: rtl/pr_isolation_ctrl.sv
module pr_isolation_ctrl
    import pr_iso_pkg::*;
#(
    parameter int DRAIN_CYCLES  = 16,
    parameter int SETTLE_CYCLES = 8,
    parameter int REG_REVISION  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        region_quiet,
    output logic        region_freeze,
    output logic        region_reset
);
    iso_state_t state;
    logic [1:0] status;
    logic       start_freeze, start_thaw;

    pr_iso_fsm #(
        .DRAIN_CYCLES  (DRAIN_CYCLES),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_freeze (start_freeze),
        .start_thaw   (start_thaw),
        .region_quiet (region_quiet),
        .state        (state),
        .status       (status),
        .freeze_o     (region_freeze)
    );

    pr_iso_regs #(
        .DW           (32),
        .REG_REVISION (REG_REVISION)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .state        (state),
        .status       (status),
        .start_freeze (start_freeze),
        .start_thaw   (start_thaw),
        .region_reset (region_reset)
    );

    // R6
    reset_within_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        region_reset |-> region_freeze);
endmodule

// File: tb/test_pr_isolation_ctrl.sv
`timescale 1ns/1ps
module test_pr_isolation_ctrl;
    localparam int DRAIN  = 16;
    localparam int SETTLE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        region_quiet = 1'b0;
    logic        region_freeze, region_reset;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pr_isolation_ctrl #(.DRAIN_CYCLES(DRAIN), .SETTLE_CYCLES(SETTLE)) i_pr_isolation_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .region_quiet(region_quiet), .region_freeze(region_freeze),
        .region_reset(region_reset)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [1:0] a, input logic [31:0] e);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, e);
    endtask

    task automatic t_reset;
        expect_reg("R1 status", 2'd0, 32'd2);
        expect_reg("R1 ctrl", 2'd1, 32'd0);
        expect_reg("R1 err", 2'd2, 32'd0);
        check("R1 freeze", {31'd0, region_freeze}, 32'd0);
        check("R1 reset", {31'd0, region_reset}, 32'd0);
    endtask

    task automatic t_revision;
        expect_reg("R2 rev", 2'd3, 32'd2);
        wr(2'd3, 32'h55);
        expect_reg("R2 rev after write", 2'd3, 32'd2);
        expect_reg("R2 status untouched", 2'd0, 32'd2);
    endtask

    task automatic t_bad_in_run;
        wr(2'd1, 32'd2);
        expect_reg("R9 err bit1", 2'd2, 32'd2);
        expect_reg("R9 ctrl unchanged", 2'd1, 32'd0);
        check("R9 reset low", {31'd0, region_reset}, 32'd0);
        wr(2'd1, 32'd4);
        expect_reg("R10 err bit2", 2'd2, 32'd6);
        expect_reg("R10 status", 2'd0, 32'd2);
        check("R10 freeze low", {31'd0, region_freeze}, 32'd0);
        wr(2'd2, 32'd0);
        expect_reg("R12 write0 no clear", 2'd2, 32'd6);
        wr(2'd2, 32'd1);
        expect_reg("R12 cleared", 2'd2, 32'd0);
    endtask

    task automatic t_multi;
        wr(2'd1, 32'd3);
        expect_reg("R11 err bit0", 2'd2, 32'd1);
        repeat (3) @(negedge clk);
        check("R11 no freeze", {31'd0, region_freeze}, 32'd0);
        expect_reg("R11 ctrl", 2'd1, 32'd0);
        wr(2'd2, 32'd1);
        wr(2'd1, 32'h0000_0101);
        expect_reg("R11 high bits", 2'd2, 32'd1);
        check("R11 high no freeze", {31'd0, region_freeze}, 32'd0);
        wr(2'd2, 32'd1);
    endtask

    task automatic t_freeze_cycle;
        wr(2'd1, 32'd1);
        check("R3 freeze on write", {31'd0, region_freeze}, 32'd1);
        expect_reg("R5 status held in drain", 2'd0, 32'd2);
        repeat (DRAIN - 1) @(negedge clk);
        expect_reg("R3 status before drain end", 2'd0, 32'd2);
        @(negedge clk);
        expect_reg("R3 status frozen", 2'd0, 32'd1);
        wr(2'd1, 32'd1);
        expect_reg("R8 err bit0", 2'd2, 32'd1);
        expect_reg("R8 status unchanged", 2'd0, 32'd1);
        wr(2'd2, 32'd1);
        wr(2'd1, 32'd2);
        check("R6 reset high", {31'd0, region_reset}, 32'd1);
        expect_reg("R6 ctrl", 2'd1, 32'd2);
        wr(2'd1, 32'd0);
        check("R13 zero accepted, reset low", {31'd0, region_reset}, 32'd0);
        expect_reg("R13 ctrl zero", 2'd1, 32'd0);
        wr(2'd1, 32'd2);
        wr(2'd1, 32'd4);
        check("R7 reset drops", {31'd0, region_reset}, 32'd0);
        check("R7 freeze held", {31'd0, region_freeze}, 32'd1);
        expect_reg("R5 status held in settle", 2'd0, 32'd1);
        repeat (SETTLE - 1) @(negedge clk);
        check("R7 freeze before settle end", {31'd0, region_freeze}, 32'd1);
        @(negedge clk);
        check("R7 freeze released", {31'd0, region_freeze}, 32'd0);
        expect_reg("R7 status run", 2'd0, 32'd2);
        wr(2'd1, 32'd0);
        expect_reg("R13 ctrl zero after thaw", 2'd1, 32'd0);
        expect_reg("R7 no errors", 2'd2, 32'd0);
    endtask

    task automatic t_quiet;
        region_quiet = 1'b1;
        wr(2'd1, 32'd1);
        expect_reg("R4 status drain", 2'd0, 32'd2);
        @(negedge clk);
        expect_reg("R4 early frozen", 2'd0, 32'd1);
        region_quiet = 1'b0;
        wr(2'd1, 32'd4);
        repeat (SETTLE) @(negedge clk);
        expect_reg("R4 back to run", 2'd0, 32'd2);
        wr(2'd1, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_revision();
        t_bad_in_run();
        t_multi();
        t_freeze_cycle();
        t_quiet();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule